// File: doc/BRIEF.md
# SD Host Command Issue and Inhibit Control

This block is the command-path controller of an SD host. Software writes a 32-bit argument and then a 16-bit command word. If the command line is free, the block takes the command. It raises a frame request toward the CMD-line serialiser and sets the inhibit flags that the command needs.

The response-type field of the command word decides what happens after the frame is sent:

- **No response:** the command finishes as soon as the serialiser reports the frame sent.
- **136-bit response:** the block stores the long response with the CRC byte removed. The stored value is the raw content moved down by eight bits.
- **48-bit response:** the block stores the 32-bit card status.
- **48-bit response with busy:** the block also holds the DAT inhibit until DAT0 goes high again.

The block counts SD clock ticks while it waits for a response and flags a timeout after 64 of them. It checks the returned index and CRC when the command word enables those checks. It reports command completion and errors in its status outputs.

The serialiser and CRC7 logic are outside the block. They are represented by a transmit-done strobe and a response-return strobe that carries the raw frame and a CRC-bad flag. A data-done strobe from the data path ends the DAT inhibit of data commands.

Top module: `sdc_cmd_issue`

## Requirements
- R1: After reset, frame_req is 0, both inhibit bits (present_state bit 0 = CMD, bit 1 = DAT) are 0, norm_status, err_status and resp are all zero.
- R2: A cmd_wr while the CMD inhibit is clear is accepted. One cycle later:
  - frame_req is 1;
  - frame_idx equals cmd_wdata[13:8];
  - frame_kind equals cmd_wdata[1:0];
  - frame_arg equals the last arg_wdata written;
  - CMD inhibit is 1.
- R3: A cmd_wr while the CMD inhibit is set is ignored: frame_idx, frame_arg and frame_req keep their values.
- R4: On acceptance, the DAT inhibit becomes 1 when the data-present bit (cmd_wdata[5]) is set or the response type is 11; otherwise it becomes 0.
- R5: For response type 00, one cycle after tx_done:
  - norm_status bit 0 (command complete) is 1;
  - the CMD inhibit is 0;
  - no response is awaited.
- R6: For response type 01 (136-bit), the stored response is resp = {8'h00, rsp_frame[127:8]}. It is due one cycle after rsp_valid, together with command complete.
- R7: For response types 10 and 11 (48-bit), resp[31:0] = rsp_frame[39:8] and the upper bits of resp are 0. Command complete is set and the CMD inhibit clears.
- R8: While a response is awaited, the 64th sd_tick without rsp_valid does the following one cycle later:
  - sets err_status bit 0 (timeout) and norm_status bit 15 (error summary);
  - clears both inhibit bits;
  - leaves command complete at 0.
- R9: With CRC check enabled (cmd_wdata[3]), rsp_crc_bad at response time sets err_status bit 1. With it disabled, no CRC error is raised.
- R10: With index check enabled (cmd_wdata[4]) and a 48-bit response type, err_status bit 2 is set when rsp_frame[45:40] differs from the command index. A 136-bit response never raises it.
- R11: For response type 11 without data, the DAT inhibit stays 1 after the response while dat_level[0] is 0. It clears one cycle after dat_level[0] is 1.
- R12: For a data command (cmd_wdata[5]=1), the DAT inhibit clears one cycle after data_done.
- R13: present_state[23:20] always equals dat_level[3:0], and norm_status bit 15 is the OR of err_status.
- R14: Writing 1 in norm_clr bit 0 clears command complete, and writing 1s in err_clr clears the matching err_status bits, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word: index [13:8], data-present 5, index check 4, CRC check 3, response type [1:0] |
| frame_req | output | 1 | Frame request to the serialiser, held until tx_done |
| frame_idx | output | 6 | Index of the launched command |
| frame_arg | output | 32 | Argument of the launched command |
| frame_kind | output | 2 | Response type of the launched command |
| tx_done | input | 1 | Serialiser has sent the command frame |
| rsp_valid | input | 1 | Response frame returned |
| rsp_frame | input | 128 | Raw response bits, CRC byte in [7:0] |
| rsp_crc_bad | input | 1 | CRC mismatch reported by the serialiser |
| sd_tick | input | 1 | One pulse per SD clock period |
| dat_level | input | 4 | Current levels of DAT[3:0] |
| data_done | input | 1 | Data phase finished |
| norm_clr | input | 16 | Write-1-to-clear for normal status |
| err_clr | input | 3 | Write-1-to-clear for error status |
| present_state | output | 32 | CMD inhibit 0, DAT inhibit 1, DAT levels [23:20] |
| norm_status | output | 16 | Command complete 0, error summary 15 |
| err_status | output | 3 | Timeout 0, CRC 1, index 2 |
| resp | output | 128 | Stored response |

## Verification
Every result of this block appears exactly one clock after the strobe that causes it:

- the frame request and both inhibit bits after an accepted command write;
- command complete, the stored response and the CRC or index errors after tx_done or rsp_valid;
- the timeout after the 64th tick;
- the busy release after DAT0 rises;
- the DAT release after data_done.

The bench drives every strobe on a falling edge for exactly one cycle. It reads the outputs on the next falling edge, so each check falls in the cycle the result is due. Just before the 64th tick the bench confirms that no timeout has been flagged yet.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int ARG_W   = 32;
    localparam int CMD_W   = 16;
    localparam int IDX_W   = 6;
    localparam int RSP_W   = 128;
    localparam int ERR_W   = 3;
    localparam int STS_W   = 16;
    localparam int PS_W    = 32;
    localparam int LINES_W = 4;
    localparam int CRC_B   = 8;
    localparam int SHORT_W = 32;

    localparam int ERR_TMO    = 0;
    localparam int ERR_CRC    = 1;
    localparam int ERR_IDX    = 2;
    localparam int STS_DONE   = 0;
    localparam int STS_ERRSUM = 15;
    localparam int PS_CMD     = 0;
    localparam int PS_DAT     = 1;
    localparam int PS_LINES   = 20;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_L136 = 2'b01,
        RSP_L48  = 2'b10,
        RSP_L48B = 2'b11
    } rsp_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             data_pres;
        logic             idx_chk;
        logic             crc_chk;
        rsp_kind_e        kind;
    } cmd_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT
    } cmd_state_e;

    function automatic cmd_word_t decode_cmd(input logic [CMD_W-1:0] w);
        cmd_word_t c;
        c.idx       = w[13:8];
        c.data_pres = w[5];
        c.idx_chk   = w[4];
        c.crc_chk   = w[3];
        c.kind      = rsp_kind_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [RSP_W-1:0] shape_resp(input logic is_long,
                                                    input logic [RSP_W-1:0] f);
        if (is_long)
            return {{CRC_B{1'b0}}, f[RSP_W-1:CRC_B]};
        return {{(RSP_W-SHORT_W){1'b0}}, f[SHORT_W+CRC_B-1:CRC_B]};
    endfunction

endpackage

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
    import sdc_pkg::*;
#(
    parameter int TMO_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  cmd_word_t        cmd_in,
    input  logic             tx_done,
    input  logic             rsp_valid,
    input  logic             rsp_crc_bad,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic             sd_tick,
    output cmd_word_t        cur_cmd,
    output logic             frame_req,
    output logic             inh_cmd,
    output logic             ev_accept,
    output logic             ev_rsp,
    output logic             ev_done,
    output logic             ev_tmo,
    output logic             ev_crc,
    output logic             ev_idx
);
    localparam int CNT_W = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_TICKS - 1);

    cmd_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        ev_accept = cmd_wr && (state == ST_IDLE);
        ev_rsp    = (state == ST_WAIT) && rsp_valid;
        ev_tmo    = (state == ST_WAIT) && !rsp_valid && sd_tick && (cnt == CNT_LAST);
        ev_done   = ev_rsp || ((state == ST_SEND) && tx_done && (cur_cmd.kind == RSP_NONE));
        ev_crc    = ev_rsp && cur_cmd.crc_chk && rsp_crc_bad;
        ev_idx    = ev_rsp && cur_cmd.idx_chk && (cur_cmd.kind != RSP_L136)
                    && (rsp_idx != cur_cmd.idx);
        frame_req = (state == ST_SEND);
        inh_cmd   = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            cur_cmd <= '0;
        end else begin
            case (state)
                ST_IDLE: if (ev_accept) begin
                    cur_cmd <= cmd_in;
                    state   <= ST_SEND;
                end
                ST_SEND: if (tx_done) begin
                    cnt   <= '0;
                    state <= (cur_cmd.kind == RSP_NONE) ? ST_IDLE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_valid || ev_tmo)
                        state <= ST_IDLE;
                    else if (sd_tick)
                        cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted command is launched with the word that was written
    assert_accept_launches_R2: assert property (@(posedge clk) disable iff (rst)
        ev_accept |=> frame_req && (cur_cmd == $past(cmd_in)));

endmodule

// File: rtl/sdc_dat_inhibit.sv
module sdc_dat_inhibit
    import sdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev_accept,
    input  cmd_word_t cmd_in,
    input  logic      ev_rsp,
    input  logic      ev_tmo,
    input  logic      data_done,
    input  logic      dat0,
    output logic      inh_dat,
    output logic      busy_wait
);
    logic need_busy;
    logic data_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            inh_dat   <= 1'b0;
            busy_wait <= 1'b0;
            need_busy <= 1'b0;
            data_cmd  <= 1'b0;
        end else if (ev_accept) begin
            inh_dat   <= cmd_in.data_pres || (cmd_in.kind == RSP_L48B);
            need_busy <= !cmd_in.data_pres && (cmd_in.kind == RSP_L48B);
            data_cmd  <= cmd_in.data_pres;
            busy_wait <= 1'b0;
        end else if (ev_tmo) begin
            inh_dat   <= 1'b0;
            busy_wait <= 1'b0;
            need_busy <= 1'b0;
            data_cmd  <= 1'b0;
        end else begin
            if (ev_rsp && need_busy)
                busy_wait <= 1'b1;
            if (busy_wait && dat0) begin
                busy_wait <= 1'b0;
                need_busy <= 1'b0;
                inh_dat   <= 1'b0;
            end
            if (data_cmd && data_done) begin
                data_cmd <= 1'b0;
                inh_dat  <= 1'b0;
            end
        end
    end

    // R11: waiting for the end of busy always keeps the DAT inhibit raised
    assert_busy_holds_dat_R11: assert property (@(posedge clk) disable iff (rst)
        busy_wait |-> inh_dat);

endmodule

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store
    import sdc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             is_long,
    input  logic [RSP_W-1:0] frame,
    output logic [RSP_W-1:0] resp
);
    localparam int N_WORDS = RSP_W / WORD_W;

    logic [RSP_W-1:0] shaped;

    always_comb shaped = shape_resp(is_long, frame);

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                resp[g*WORD_W +: WORD_W] <= '0;
            else if (capture)
                resp[g*WORD_W +: WORD_W] <= shaped[g*WORD_W +: WORD_W];
        end
    end

    // R6: a long response never keeps anything in the top byte
    assert_long_top_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (capture && is_long) |=> (resp[RSP_W-1 -: CRC_B] == '0));

endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
    import sdc_pkg::*;
#(
    parameter int TMO_TICKS = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arg_wr,
    input  logic [ARG_W-1:0]   arg_wdata,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_wdata,
    output logic               frame_req,
    output logic [IDX_W-1:0]   frame_idx,
    output logic [ARG_W-1:0]   frame_arg,
    output logic [1:0]         frame_kind,
    input  logic               tx_done,
    input  logic               rsp_valid,
    input  logic [RSP_W-1:0]   rsp_frame,
    input  logic               rsp_crc_bad,
    input  logic               sd_tick,
    input  logic [LINES_W-1:0] dat_level,
    input  logic               data_done,
    input  logic [STS_W-1:0]   norm_clr,
    input  logic [ERR_W-1:0]   err_clr,
    output logic [PS_W-1:0]    present_state,
    output logic [STS_W-1:0]   norm_status,
    output logic [ERR_W-1:0]   err_status,
    output logic [RSP_W-1:0]   resp
);
    cmd_word_t        cmd_in;
    cmd_word_t        cur_cmd;
    logic [ARG_W-1:0] arg_q;
    logic             inh_cmd, inh_dat, busy_wait;
    logic             ev_accept, ev_rsp, ev_done, ev_tmo, ev_crc, ev_idx;
    logic             done_q;
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_set;

    always_comb cmd_in = decode_cmd(cmd_wdata);

    sdc_cmd_fsm #(.TMO_TICKS(TMO_TICKS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_in     (cmd_in),
        .tx_done    (tx_done),
        .rsp_valid  (rsp_valid),
        .rsp_crc_bad(rsp_crc_bad),
        .rsp_idx    (rsp_frame[45:40]),
        .sd_tick    (sd_tick),
        .cur_cmd    (cur_cmd),
        .frame_req  (frame_req),
        .inh_cmd    (inh_cmd),
        .ev_accept  (ev_accept),
        .ev_rsp     (ev_rsp),
        .ev_done    (ev_done),
        .ev_tmo     (ev_tmo),
        .ev_crc     (ev_crc),
        .ev_idx     (ev_idx)
    );

    sdc_dat_inhibit u_dat (
        .clk      (clk),
        .rst      (rst),
        .ev_accept(ev_accept),
        .cmd_in   (cmd_in),
        .ev_rsp   (ev_rsp),
        .ev_tmo   (ev_tmo),
        .data_done(data_done),
        .dat0     (dat_level[0]),
        .inh_dat  (inh_dat),
        .busy_wait(busy_wait)
    );

    sdc_rsp_store u_store (
        .clk    (clk),
        .rst    (rst),
        .capture(ev_rsp),
        .is_long(cur_cmd.kind == RSP_L136),
        .frame  (rsp_frame),
        .resp   (resp)
    );

    always_comb begin
        err_set          = '0;
        err_set[ERR_TMO] = ev_tmo;
        err_set[ERR_CRC] = ev_crc;
        err_set[ERR_IDX] = ev_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q     <= '0;
            frame_arg <= '0;
            done_q    <= 1'b0;
            err_q     <= '0;
        end else begin
            if (arg_wr)
                arg_q <= arg_wdata;
            if (ev_accept)
                frame_arg <= arg_q;
            if (ev_done)
                done_q <= 1'b1;
            else if (norm_clr[STS_DONE])
                done_q <= 1'b0;
            err_q <= err_set | (err_q & ~err_clr);
        end
    end

    always_comb begin
        frame_idx                                 = cur_cmd.idx;
        frame_kind                                = cur_cmd.kind;
        present_state                             = '0;
        present_state[PS_CMD]                     = inh_cmd;
        present_state[PS_DAT]                     = inh_dat;
        present_state[PS_LINES +: LINES_W]        = dat_level;
        norm_status                               = '0;
        norm_status[STS_DONE]                     = done_q;
        norm_status[STS_ERRSUM]                   = |err_q;
        err_status                                = err_q;
    end

    // R3: a command write during CMD inhibit leaves the launched command alone
    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && present_state[PS_CMD]) |=> ($stable(frame_idx) && $stable(frame_arg)));

    // R5: completion is never reported while the CMD line is still claimed
    assert_done_frees_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(norm_status[STS_DONE]) |-> !present_state[PS_CMD]);

    // R8: a timeout releases both inhibits
    assert_timeout_releases_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_status[ERR_TMO]) |-> (present_state[1:0] == 2'b00));

endmodule

// File: tb/test_sdc_cmd_issue.sv
module test_sdc_cmd_issue;

    logic         clk = 1'b0;
    logic         rst;
    logic         arg_wr, cmd_wr, tx_done, rsp_valid, rsp_crc_bad, sd_tick, data_done;
    logic [31:0]  arg_wdata;
    logic [15:0]  cmd_wdata, norm_clr;
    logic [127:0] rsp_frame, resp;
    logic [3:0]   dat_level;
    logic [2:0]   err_clr, err_status;
    logic         frame_req;
    logic [5:0]   frame_idx;
    logic [31:0]  frame_arg, present_state;
    logic [1:0]   frame_kind;
    logic [15:0]  norm_status;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdc_cmd_issue i_sdc_cmd_issue (
        .clk(clk), .rst(rst), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .frame_req(frame_req),
        .frame_idx(frame_idx), .frame_arg(frame_arg), .frame_kind(frame_kind),
        .tx_done(tx_done), .rsp_valid(rsp_valid), .rsp_frame(rsp_frame),
        .rsp_crc_bad(rsp_crc_bad), .sd_tick(sd_tick), .dat_level(dat_level),
        .data_done(data_done), .norm_clr(norm_clr), .err_clr(err_clr),
        .present_state(present_state), .norm_status(norm_status),
        .err_status(err_status), .resp(resp)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [127:0] exp_resp(input logic [1:0] kind, input logic [127:0] f);
        if (kind == 2'b01) return {8'h00, f[127:8]};
        return {96'h0, f[39:8]};
    endfunction

    function automatic logic [2:0] exp_err(input logic [1:0] kind, input logic cc, input logic ic,
                                           input logic crcbad, input logic idxbad);
        logic [2:0] e;
        e    = 3'b000;
        e[1] = cc && crcbad;
        e[2] = ic && idxbad && (kind[1] == 1'b1);
        return e;
    endfunction

    task automatic run_cmd(input logic [5:0] idx, input logic [1:0] kind, input logic dp,
                           input logic cc, input logic ic, input logic tmo,
                           input logic crcbad, input logic idxbad, input logic poke);
        logic [31:0]  a;
        logic [127:0] fr;
        logic [2:0]   ee;
        int           k;
        a  = $urandom;
        fr = {$urandom, $urandom, $urandom, $urandom};
        fr[45:40] = idxbad ? (idx ^ 6'h2A) : idx;
        dat_level = 4'($urandom);
        @(negedge clk);
        chk("R13 dat lines", 128'(present_state[23:20]), 128'(dat_level));
        arg_wr = 1'b1; arg_wdata = a;
        @(negedge clk);
        arg_wr = 1'b0; cmd_wr = 1'b1;
        cmd_wdata = {2'b00, idx, 2'b00, dp, ic, cc, 1'b0, kind};
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R2 frame_req", 128'(frame_req), 128'(1));
        chk("R2 frame_idx", 128'(frame_idx), 128'(idx));
        chk("R2 frame_arg", 128'(frame_arg), 128'(a));
        chk("R2 frame_kind", 128'(frame_kind), 128'(kind));
        chk("R2 cmd inhibit", 128'(present_state[0]), 128'(1));
        chk("R4 dat inhibit", 128'(present_state[1]), 128'(dp || kind == 2'b11));
        if (poke) begin
            cmd_wr = 1'b1; cmd_wdata = {2'b00, idx ^ 6'h01, 8'h02};
            arg_wr = 1'b0;
            @(negedge clk);
            cmd_wr = 1'b0;
            chk("R3 idx kept", 128'(frame_idx), 128'(idx));
            chk("R3 req kept", 128'(frame_req), 128'(1));
            chk("R3 kind kept", 128'(frame_kind), 128'(kind));
        end
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        if (kind == 2'b00) begin
            chk("R5 complete", 128'(norm_status), 128'(16'h0001));
            chk("R5 cmd inhibit", 128'(present_state[0]), 128'(0));
        end else begin
            chk("R2 req drops", 128'(frame_req), 128'(0));
            if (tmo) begin
                for (int i = 0; i < 64; i++) begin
                    if (i == 63) chk("R8 no early timeout", 128'(err_status), 128'(0));
                    sd_tick = 1'b1;
                    @(negedge clk);
                end
                sd_tick = 1'b0;
                chk("R8 timeout err", 128'(err_status), 128'(3'b001));
                chk("R8 status", 128'(norm_status), 128'(16'h8000));
                chk("R8 inhibits", 128'(present_state[1:0]), 128'(0));
            end else begin
                k = $urandom % 40;
                for (int i = 0; i < k; i++) begin
                    sd_tick = 1'b1;
                    @(negedge clk);
                end
                sd_tick = 1'b0;
                if (kind == 2'b11 && !dp) dat_level = 4'h0;
                rsp_valid = 1'b1; rsp_frame = fr; rsp_crc_bad = crcbad;
                @(negedge clk);
                rsp_valid = 1'b0; rsp_crc_bad = 1'b0;
                ee = exp_err(kind, cc, ic, crcbad, idxbad);
                chk(kind == 2'b01 ? "R6 long resp" : "R7 short resp", resp, exp_resp(kind, fr));
                chk("R9 R10 errors", 128'(err_status), 128'(ee));
                chk("R7 R13 status", 128'(norm_status), 128'({|ee, 14'h0, 1'b1}));
                chk("R7 cmd inhibit", 128'(present_state[0]), 128'(0));
                if (kind == 2'b11 && !dp) begin
                    chk("R11 busy held", 128'(present_state[1]), 128'(1));
                    repeat (3) @(negedge clk);
                    chk("R11 busy still", 128'(present_state[1]), 128'(1));
                    dat_level = 4'hF;
                    @(negedge clk);
                    chk("R11 busy end", 128'(present_state[1]), 128'(0));
                end
            end
        end
        if (dp && !(tmo && kind != 2'b00)) begin
            chk("R12 dat held", 128'(present_state[1]), 128'(1));
            data_done = 1'b1;
            @(negedge clk);
            data_done = 1'b0;
            chk("R12 dat released", 128'(present_state[1]), 128'(0));
        end
        if (kind == 2'b00 && !dp)
            chk("R4 no dat", 128'(present_state[1]), 128'(0));
        norm_clr = 16'hFFFF; err_clr = 3'b111;
        @(negedge clk);
        norm_clr = '0; err_clr = '0;
        chk("R14 norm cleared", 128'(norm_status), 128'(0));
        chk("R14 err cleared", 128'(err_status), 128'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; arg_wr = 0; cmd_wr = 0; tx_done = 0; rsp_valid = 0; rsp_crc_bad = 0;
        sd_tick = 0; data_done = 0; arg_wdata = '0; cmd_wdata = '0; norm_clr = '0;
        err_clr = '0; rsp_frame = '0; dat_level = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 frame_req", 128'(frame_req), 128'(0));
        chk("R1 inhibits", 128'(present_state[1:0]), 128'(0));
        chk("R1 status", 128'({norm_status, err_status}), 128'(0));
        chk("R1 resp", resp, 128'(0));

        run_cmd(6'd0,  2'b00, 0, 0, 0, 0, 0, 0, 0);   // R5 plain
        run_cmd(6'd2,  2'b01, 0, 1, 1, 0, 0, 1, 0);   // R6, R10 ignored on long
        run_cmd(6'd17, 2'b10, 0, 1, 0, 0, 1, 0, 0);   // R9 enabled
        run_cmd(6'd17, 2'b10, 0, 0, 0, 0, 1, 0, 0);   // R9 disabled
        run_cmd(6'd13, 2'b10, 0, 0, 1, 0, 0, 1, 0);   // R10 mismatch
        run_cmd(6'd7,  2'b11, 0, 1, 1, 0, 0, 0, 0);   // R11 busy
        run_cmd(6'd18, 2'b10, 1, 1, 1, 0, 0, 0, 0);   // R12 data
        run_cmd(6'd8,  2'b10, 0, 0, 0, 1, 0, 0, 0);   // R8 timeout
        run_cmd(6'd24, 2'b10, 1, 0, 0, 1, 0, 0, 0);   // R8 timeout with data
        run_cmd(6'd5,  2'b10, 0, 0, 0, 0, 0, 0, 1);   // R3 write during inhibit

        for (int n = 0; n < 40; n++) begin
            run_cmd(6'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 8) == 0, 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
        end

        summary();
        $finish;
    end

endmodule